// File: doc/BRIEF.md
# Twisted-Pair Line Status Indicator

This block drives the three status pins of a twisted-pair port: transmit-enable, receive-carrier and collision. Each pin has a level and its own output-enable, so a pad cell outside the block can float it. The block takes in the link state, the already-qualified transmit and receive activity, the jabber state, a sleep pin and an output-enable configuration bit. It settles which of them wins, and it registers the result so that every pin changes one clock after its inputs.

The block also returns a registered collision indication to the MAC core. It raises a sticky collision-error flag when a transmission ends while the link is down. In that state no heartbeat can come back, so the missing heartbeat is a real fault. When the link is up, the end of a transmission raises no error. No data stream passes through this block. Every port is a plain control or status signal with no valid/ready handshake, so back-pressure does not apply.

Top module: `tp_status_ind`

## Requirements
- R1: While reset is asserted and on the first edge after it, all three output-enables, all three pin levels, the MAC collision indication and the collision-error flag are 0.
- R2: The three output-enables are always equal to each other. One cycle after a clock edge, they are 1 only if three conditions held at that edge: the configuration bit was 1, the sleep pin was 0, and link pass had been seen at that edge or at any earlier edge since reset.
- R3: In link pass without jabber, the transmit-enable pin equals the transmit activity and the receive-carrier pin equals the receive activity of the previous edge.
- R4: In link pass without jabber, simultaneous transmit and receive activity sets the collision pin and the MAC collision indication to 1 one cycle later, and transmit-enable and receive-carrier are 1 as well.
- R5: In link fail, all three pin levels and the MAC collision indication are 0 one cycle later, whatever the activity or jabber inputs are. The output-enables stay as R2 gives them.
- R6: In link pass with jabber set, the collision pin and the MAC collision indication are 1, transmit-enable is 0 whatever the transmit activity is, and receive-carrier follows the receive activity.
- R7: While the sleep pin is 1, all three output-enables are 0 on the next cycle, whatever the other inputs are.
- R8: The collision-error flag becomes 1 one cycle after an edge where transmit activity goes from 1 to 0 while the link is in fail. The same falling edge in link pass leaves the flag unchanged.
- R9: Once set, the collision-error flag stays 1 until an edge where the clear input is 1 and no new error is being set. A new error and a clear in the same cycle leave the flag at 1.
- R10: Clearing the configuration bit drops all three output-enables one cycle later, even in link pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_ok | input | 1 | 1 = link pass, 0 = link fail |
| tx_act | input | 1 | Qualified transmit activity |
| rx_act | input | 1 | Qualified receive activity |
| jabber | input | 1 | Jabber state active |
| sleep_pin | input | 1 | Sleep request; floats all pins |
| pin_en_cfg | input | 1 | Configuration bit allowing the pins to be driven |
| cerr_clr | input | 1 | One-cycle clear of the collision-error flag |
| txen_o | output | 1 | Transmit-enable pin level |
| txen_oe | output | 1 | Transmit-enable output-enable |
| crs_o | output | 1 | Receive-carrier pin level |
| crs_oe | output | 1 | Receive-carrier output-enable |
| col_o | output | 1 | Collision pin level |
| col_oe | output | 1 | Collision output-enable |
| mac_col | output | 1 | Collision indication to the MAC core |
| cerr_flag | output | 1 | Sticky collision-error interrupt condition |

## Verification
The assertions assume that every input is synchronous to the clock and stable across each rising edge. They also assume that the clear input is a single-cycle pulse and that the inputs sit at 0 while reset is held. The bench changes inputs only 1 ns after a rising edge and holds them for the whole cycle. It keeps every input low during reset and raises the clear for exactly one step at a time, so the stimulus stays within those assumptions.

// File: rtl/tp_status_pkg.sv
package tp_status_pkg;
  localparam int NUM_PINS = 3;
  localparam int PIN_TXEN = 0;
  localparam int PIN_CRS  = 1;
  localparam int PIN_COL  = 2;

  typedef logic [NUM_PINS-1:0] pin_vec_t;
endpackage

// File: rtl/tp_pin_level.sv
module tp_pin_level
  import tp_status_pkg::*;
(
  input  logic     link_ok,
  input  logic     tx_act,
  input  logic     rx_act,
  input  logic     jabber,
  output pin_vec_t lvl,
  output logic     col_int
);
  logic both_act;
  assign both_act = tx_act & rx_act;

  always_comb begin
    lvl     = '0;
    col_int = 1'b0;
    if (link_ok) begin
      if (jabber) begin
        // jabber masks transmit and forces collision
        lvl[PIN_TXEN] = 1'b0;
        lvl[PIN_CRS]  = rx_act;
        lvl[PIN_COL]  = 1'b1;
        col_int       = 1'b1;
      end else begin
        lvl[PIN_TXEN] = tx_act;
        lvl[PIN_CRS]  = rx_act;
        lvl[PIN_COL]  = both_act;
        col_int       = both_act;
      end
    end
  end
endmodule

// File: rtl/tp_pin_gate.sv
module tp_pin_gate
  import tp_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     link_ok,
  input  logic     sleep_pin,
  input  logic     pin_en_cfg,
  input  pin_vec_t lvl_in,
  output pin_vec_t lvl_q,
  output pin_vec_t oe_q
);
  logic seen_pass_q;
  logic drive_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_pass_q <= 1'b0;
    else if (link_ok) seen_pass_q <= 1'b1;
  end

  // sleep beats the enable bit, and the enable bit beats the link history
  assign drive_ok = !sleep_pin && pin_en_cfg && (seen_pass_q || link_ok);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[g] <= 1'b0;
        oe_q[g]  <= 1'b0;
      end else begin
        lvl_q[g] <= lvl_in[g];
        oe_q[g]  <= drive_ok;
      end
    end
  end
endmodule

// File: rtl/tp_hb_err.sv
module tp_hb_err (
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  input  logic tx_act,
  input  logic clr,
  output logic flag
);
  logic tx_q;
  logic tx_end;

  assign tx_end = tx_q && !tx_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
      flag <= 1'b0;
    end else begin
      tx_q <= tx_act;
      if (tx_end && !link_ok) flag <= 1'b1;
      else if (clr)           flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tp_status_ind.sv
module tp_status_ind
  import tp_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  input  logic tx_act,
  input  logic rx_act,
  input  logic jabber,
  input  logic sleep_pin,
  input  logic pin_en_cfg,
  input  logic cerr_clr,
  output logic txen_o,
  output logic txen_oe,
  output logic crs_o,
  output logic crs_oe,
  output logic col_o,
  output logic col_oe,
  output logic mac_col,
  output logic cerr_flag
);
  pin_vec_t lvl_d, lvl_q, oe_q;
  logic     col_int;

  tp_pin_level u_level (
    .link_ok (link_ok),
    .tx_act  (tx_act),
    .rx_act  (rx_act),
    .jabber  (jabber),
    .lvl     (lvl_d),
    .col_int (col_int)
  );

  tp_pin_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_ok    (link_ok),
    .sleep_pin  (sleep_pin),
    .pin_en_cfg (pin_en_cfg),
    .lvl_in     (lvl_d),
    .lvl_q      (lvl_q),
    .oe_q       (oe_q)
  );

  tp_hb_err u_hb (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_ok (link_ok),
    .tx_act  (tx_act),
    .clr     (cerr_clr),
    .flag    (cerr_flag)
  );

  // MAC copy is not gated by sleep or output-enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mac_col <= 1'b0;
    else        mac_col <= col_int;
  end

  assign txen_o  = lvl_q[PIN_TXEN];
  assign crs_o   = lvl_q[PIN_CRS];
  assign col_o   = lvl_q[PIN_COL];
  assign txen_oe = oe_q[PIN_TXEN];
  assign crs_oe  = oe_q[PIN_CRS];
  assign col_oe  = oe_q[PIN_COL];
endmodule

// File: rtl/tp_status_ind_chk.sv
module tp_status_ind_chk (
  input logic clk,
  input logic rst_n,
  input logic link_ok,
  input logic tx_act,
  input logic rx_act,
  input logic jabber,
  input logic sleep_pin,
  input logic pin_en_cfg,
  input logic cerr_clr,
  input logic txen_o,
  input logic txen_oe,
  input logic crs_o,
  input logic crs_oe,
  input logic col_o,
  input logic col_oe,
  input logic mac_col,
  input logic cerr_flag
);
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!txen_oe && !crs_oe && !col_oe && !cerr_flag && !mac_col);
    end
  end

  p_oe_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txen_oe == crs_oe) && (crs_oe == col_oe));

  p_oe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_oe |-> $past(pin_en_cfg && !sleep_pin));

  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && link_ok && !jabber) |-> (txen_o == $past(tx_act)) && (crs_o == $past(rx_act)));

  p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && link_ok && tx_act && rx_act) |-> col_o && mac_col);

  p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!link_ok) |-> !txen_o && !crs_o && !col_o && !mac_col);

  p_jab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(jabber) |-> !txen_o);

  p_jab_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && link_ok && jabber) |-> col_o && mac_col);

  p_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_pin) |-> !txen_oe && !crs_oe && !col_oe);

  p_cerr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(tx_act, 2) && $past(!tx_act && !link_ok)) |-> cerr_flag);

  p_cerr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cerr_flag) |-> $past(!link_ok));

  p_cerr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && cerr_flag && !cerr_clr) |-> cerr_flag);

  p_cfg_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pin_en_cfg) |-> !col_oe);
endmodule

bind tp_status_ind tp_status_ind_chk u_chk (.*);

// File: tb/tp_status_ind_test.sv
module tp_status_ind_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_ok = 0, tx_act = 0, rx_act = 0, jabber = 0;
  logic sleep_pin = 0, pin_en_cfg = 0, cerr_clr = 0;
  logic txen_o, txen_oe, crs_o, crs_oe, col_o, col_oe, mac_col, cerr_flag;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         tgt;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  // model state
  bit m_seen = 0, m_txq = 0, m_cerr = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tp_status_ind uut (.*);

  function automatic logic [7:0] out_vec();
    return {txen_oe, crs_oe, col_oe, txen_o, crs_o, col_o, mac_col, cerr_flag};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (oe3,lvl3,mac,cerr)", tag, act, exp);
    end
  endtask

  // drive one cycle and record what must appear after the next edge
  task automatic step(input bit lk, tx, rx, jb, sl, cf, cl, input string tag);
    bit oe, t, c, k, mc, ce;
    item_t it;
    @(posedge clk);
    #1;
    link_ok = lk; tx_act = tx; rx_act = rx; jabber = jb;
    sleep_pin = sl; pin_en_cfg = cf; cerr_clr = cl;
    oe = !sl && cf && (m_seen || lk);
    t = 0; c = 0; k = 0;
    if (lk) begin
      if (jb) begin t = 0; c = rx; k = 1; end
      else begin t = tx; c = rx; k = tx && rx; end
    end
    mc = k;
    ce = (m_txq && !tx && !lk) ? 1'b1 : (cl ? 1'b0 : m_cerr);
    m_cerr = ce; m_txq = tx; m_seen = m_seen || lk;
    it.tgt = cyc + 1;
    it.exp = {oe, oe, oe, t, c, k, mc, ce};
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #6;
      while (sb.size() > 0 && sb[0].tgt <= cyc) begin
        item_t it;
        it = sb.pop_front();
        check(out_vec(), it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    check(out_vec(), 8'b0, "R1 during reset");
    @(posedge clk); #1 rst_n = 1'b1;
    // R1: first edge after reset with inputs low
    step(0,0,0,0,0,0,0, "R1 first edge");
    // R2: enabled but link never passed -> floating
    step(0,1,1,0,0,1,0, "R2 no pass yet");
    step(0,0,0,0,0,1,0, "R2 no pass yet idle");
    // R10: link pass, enable clear
    step(1,0,0,0,0,0,0, "R10 cfg off in pass");
    // R2: enable on
    step(1,0,0,0,0,1,0, "R2 driven");
    // R3
    step(1,1,0,0,0,1,0, "R3 tx only");
    step(1,0,1,0,0,1,0, "R3 rx only");
    step(1,0,0,0,0,1,0, "R3 idle");
    // R8: falling tx in link pass, no error
    step(1,1,0,0,0,1,0, "R3 tx again");
    step(1,0,0,0,0,1,0, "R8 end tx in pass");
    // R4
    step(1,1,1,0,0,1,0, "R4 collision");
    step(1,1,1,0,0,1,0, "R4 collision hold");
    // R6
    step(1,1,0,1,0,1,0, "R6 jabber tx");
    step(1,0,0,1,0,1,0, "R6 jabber idle");
    step(1,1,1,1,0,1,0, "R6 jabber rx");
    // R7
    step(1,1,1,0,1,1,0, "R7 sleep");
    step(1,0,0,1,1,1,0, "R7 sleep jabber");
    step(1,0,0,0,0,1,0, "R7 wake");
    // R5: link fail after pass stays driven but quiet
    step(0,1,1,1,0,1,0, "R5 fail active");
    step(0,0,1,0,0,1,0, "R8 end tx in fail");
    step(0,0,0,0,0,1,0, "R9 hold");
    step(0,0,0,0,0,1,1, "R9 clear");
    step(0,0,0,0,0,1,0, "R9 cleared");
    // R9: set and clear together
    step(0,1,0,0,0,1,0, "R5 tx in fail");
    step(0,0,0,0,0,1,1, "R9 set beats clear");
    step(0,0,0,0,0,1,0, "R9 stays set");
    step(1,0,0,0,0,1,1, "R9 clear in pass");
    step(0,0,0,0,1,1,0, "R7 sleep in fail");
    step(0,0,0,0,0,0,0, "R10 cfg off in fail");
    repeat (3) @(posedge clk);
    #8;
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule